// File: doc/BRIEF.md
# Multi-Width Multiply-Accumulate Register Block

This block sits on a 16-bit register bus and multiplies two operands that can each be 8, 16, 24 or 32 bits wide. It can also add the product into the 64-bit result it already holds. Software chooses the operation through the address that receives the first operand. That address selects unsigned or signed arithmetic, and plain multiply or multiply-accumulate. Software chooses each operand's width through the address it writes and through the byte qualifier on the write. A byte write uses only the low eight data bits. Writing the second operand starts the work. When the second operand is 32 bits wide, the low half is written first and the high half after it.

The arithmetic runs on a single 17x17 signed multiplier. Each operand is split into 16-bit halves, and the block handles one partial product per clock, adding each into a product accumulator. The visible result is that accumulator plus a base value. The base is zero for a multiply and the previous result for an accumulate. The 64-bit result is read as four 16-bit words. Three extra registers serve 16x16-style software: a low word, a high word and a sign/carry extension word.

Each result word and the carry flag has its own ready timer, loaded from the operand-size class. A read of a word that is not yet ready raises a wait signal in that cycle.

Top module: `mw_mac_unit`

## Requirements
- R1: Word addresses 0,1,2,3 take a 8/16-bit first operand, and 8,9,10,11 take the low half of a 24/32-bit first operand. Within each group the offset selects, in order: unsigned multiply, signed multiply, unsigned accumulate, signed accumulate. Address 12 takes the first operand's high half. Address 4 takes a 8/16-bit second operand, 13 the low half of a 24/32-bit second operand, and 14 its high half.
- R2: A byte write (wr_byte=1) uses wdata[7:0]. It gives an 8-bit operand at addresses 0-4, or a 24-bit operand at addresses 12 and 14. Signed operations sign-extend from bit 7, 15 or 23; unsigned operations zero-extend.
- R3: A multiply leaves the exact 64-bit product, under the selected signedness, in result words at addresses 16 (least significant) through 19.
- R4: An accumulate leaves the old 64-bit result plus the product, modulo 2^64. The carry out of that sum appears at address 20, bit 0. A multiply leaves that flag at 0.
- R5: Address 5 reads result word 0 and address 6 reads word 1. Address 7 reads 0xFFFF when a signed operation leaves result bit 31 set and 0x0000 otherwise. For an unsigned operation, address 7 reads the carry flag.
- R6: A read whose address is sampled at the Nth rising edge after the starting write's edge, or later, sees that word ready; at edge N-1 it does not. For 8/16 x 8/16, N is 3,3,4,4 for words 0-3 and 3 for the carry flag.
- R7: For a 24/32-bit first operand with a 8/16-bit second operand, N is 3,5,6,7 for the words and 7 for the carry.
- R8: With a 24/32-bit second operand, readiness counts from the high-half write. The deadline is the later of the low-half deadline and the high-half deadline. For a 8/16-bit first operand these are 3,5,6,7,7 and 3,4,4,4,4 (words 0-3, then carry); for a 24/32-bit first operand they are 3,8,10,11,11 and 3,5,6,6,6. No result word is ready while the high half is still missing.
- R9: rd_wait is high only when rd_en is high and the addressed result word, compatibility word or carry flag is not ready.
- R10: After synchronous reset all result words and the carry flag read 0, and no read waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_byte | input | 1 | Write carries only the low byte |
| addr | input | 5 | Word address for the write or read |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 16 | Read data for addr |
| rd_wait | output | 1 | Addressed result is not yet ready |

## Verification
Directed cases cover the sign-extension edges: a signed all-ones byte, an unsigned all-ones byte, the most negative 32-bit value squared, and a signed 24-bit pair. Together they show whether extension uses bit 7, 15 or 23 and whether halves are split as signed or unsigned. An unsigned accumulate of two maximal 32-bit products is followed by a multiply. This forces the carry flag to 1 and then back to 0. Random operations mix all four operation kinds, all width pairs and several gaps between the two halves of the second operand. They compare every word, the carry flag and the first-ready cycle of each word against tables in the bench, so a wrong partial-product weight or a wrong timer class shows up.

// File: rtl/mwmac_pkg.sv
package mwmac_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int RES_W    = 64;
    localparam int CNT_W    = 4;
    localparam int N_TRACK  = 5;   // four result words plus the carry flag

    typedef enum logic [1:0] {
        OP_MUL_U = 2'd0,
        OP_MUL_S = 2'd1,
        OP_MAC_U = 2'd2,
        OP_MAC_S = 2'd3
    } op_kind_e;

    localparam logic [ADDR_W-1:0] A_OP2     = 5'd4;
    localparam logic [ADDR_W-1:0] A_CLO     = 5'd5;
    localparam logic [ADDR_W-1:0] A_CHI     = 5'd6;
    localparam logic [ADDR_W-1:0] A_CEXT    = 5'd7;
    localparam logic [ADDR_W-1:0] A_OP1_HI  = 5'd12;
    localparam logic [ADDR_W-1:0] A_OP2_LO  = 5'd13;
    localparam logic [ADDR_W-1:0] A_OP2_HI  = 5'd14;
    localparam logic [ADDR_W-1:0] A_RW0     = 5'd16;
    localparam logic [ADDR_W-1:0] A_RW1     = 5'd17;
    localparam logic [ADDR_W-1:0] A_RW2     = 5'd18;
    localparam logic [ADDR_W-1:0] A_RW3     = 5'd19;
    localparam logic [ADDR_W-1:0] A_CARRY   = 5'd20;

    typedef logic [N_TRACK-1:0][CNT_W-1:0] sched_t;

    function automatic logic is_signed(input op_kind_e k);
        return k[0];
    endfunction

    function automatic logic is_accum(input op_kind_e k);
        return k[1];
    endfunction

    // Byte writes extend their low byte to a 16-bit half.
    function automatic logic [DATA_W-1:0] ext_half(input logic [DATA_W-1:0] d,
                                                   input logic byte_wr,
                                                   input logic sg);
        return byte_wr ? {{8{sg & d[7]}}, d[7:0]} : d;
    endfunction

    // Ready deadlines: index 0..3 result words, 4 carry flag.
    function automatic sched_t sched_lookup(input logic w1_wide,
                                            input logic w2_wide,
                                            input logic hi_phase);
        int     t [N_TRACK];
        sched_t s;
        case ({w2_wide, hi_phase, w1_wide})
            3'b001:  t = '{3, 5, 6, 7, 7};
            3'b100:  t = '{3, 5, 6, 7, 7};
            3'b101:  t = '{3, 8, 10, 11, 11};
            3'b110:  t = '{3, 4, 4, 4, 4};
            3'b111:  t = '{3, 5, 6, 6, 6};
            default: t = '{3, 3, 4, 4, 3};
        endcase
        for (int i = 0; i < N_TRACK; i++) s[i] = CNT_W'(t[i]);
        return s;
    endfunction

    function automatic logic [CNT_W-1:0] cnt_max(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mwmac_regif.sv
module mwmac_regif
    import mwmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [31:0]       op1,
    output logic [31:0]       op2,
    output op_kind_e          kind,
    output logic              op1_wide,
    output logic              await_hi,
    output logic              start,
    output logic              start_wide,
    output logic              hi_load
);

    logic              sel_op1_n;
    logic              sel_op1_w;
    logic              cur_sg;
    logic              new_sg;
    logic [DATA_W-1:0] half_cur;
    logic [DATA_W-1:0] half_new;

    assign sel_op1_n  = (addr[4:2] == 3'b000);
    assign sel_op1_w  = (addr[4:2] == 3'b010);
    assign cur_sg     = is_signed(kind);
    assign new_sg     = addr[0];
    assign half_cur   = ext_half(wdata, wr_byte, cur_sg);
    assign half_new   = ext_half(wdata, wr_byte, new_sg);

    assign start      = wr_en && ((addr == A_OP2) || (addr == A_OP2_LO));
    assign start_wide = (addr == A_OP2_LO);
    assign hi_load    = wr_en && (addr == A_OP2_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            op1      <= '0;
            op2      <= '0;
            kind     <= OP_MUL_U;
            op1_wide <= 1'b0;
            await_hi <= 1'b0;
        end else if (wr_en) begin
            if (sel_op1_n) begin
                kind     <= op_kind_e'(addr[1:0]);
                op1      <= {{16{new_sg & half_new[15]}}, half_new};
                op1_wide <= 1'b0;
            end else if (sel_op1_w) begin
                kind     <= op_kind_e'(addr[1:0]);
                op1      <= {16'h0000, wdata};
                op1_wide <= 1'b1;
            end else if (addr == A_OP1_HI) begin
                op1[31:16] <= half_cur;
            end else if (addr == A_OP2) begin
                op2      <= {{16{cur_sg & half_cur[15]}}, half_cur};
                await_hi <= 1'b0;
            end else if (addr == A_OP2_LO) begin
                op2      <= {16'h0000, wdata};
                await_hi <= 1'b1;
            end else if (addr == A_OP2_HI) begin
                op2[31:16] <= half_cur;
                await_hi   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mwmac_engine.sv
module mwmac_engine
    import mwmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_wide,
    input  logic             hi_load,
    input  op_kind_e         kind,
    input  logic [31:0]      op1,
    input  logic [31:0]      op2,
    input  logic             op1_wide,
    output logic [RES_W-1:0] res,
    output logic             carry,
    output logic             run_signed,
    output logic [3:0]       pend
);

    op_kind_e          run_kind;
    logic              run_w1;
    logic              run_w2;
    logic [RES_W-1:0]  base;
    logic [RES_W-1:0]  pacc;
    logic [RES_W:0]    total;
    logic [1:0]        sel;
    logic              sg;
    logic signed [16:0] pa;
    logic signed [16:0] pb;
    logic signed [33:0] pp;
    logic [RES_W-1:0]  pext;
    logic [RES_W-1:0]  pshift;
    logic [3:0]        done_bit;
    logic [3:0]        add_bits;

    assign sg = is_signed(run_kind);

    // Lowest pending partial product goes first.
    always_comb begin
        if (pend[0])      sel = 2'd0;
        else if (pend[1]) sel = 2'd1;
        else if (pend[2]) sel = 2'd2;
        else              sel = 2'd3;
    end

    always_comb begin
        if (sel[0]) pa = {sg & op1[31], op1[31:16]};
        else        pa = {~run_w1 & sg & op1[15], op1[15:0]};
        if (sel[1]) pb = {sg & op2[31], op2[31:16]};
        else        pb = {~run_w2 & sg & op2[15], op2[15:0]};
        pp   = pa * pb;
        pext = {{(RES_W-34){pp[33]}}, pp};
        case (sel)
            2'd0:    pshift = pext;
            2'd3:    pshift = pext << 32;
            default: pshift = pext << 16;
        endcase
    end

    assign done_bit = (|pend) ? (4'b0001 << sel) : 4'b0000;
    assign add_bits = hi_load ? {op1_wide, 1'b1, 2'b00} : 4'b0000;

    assign total      = {1'b0, base} + {1'b0, pacc};
    assign res        = total[RES_W-1:0];
    assign carry      = total[RES_W];
    assign run_signed = sg;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_kind <= OP_MUL_U;
            run_w1   <= 1'b0;
            run_w2   <= 1'b0;
            base     <= '0;
            pacc     <= '0;
            pend     <= '0;
        end else if (start) begin
            run_kind <= kind;
            run_w1   <= op1_wide;
            run_w2   <= start_wide;
            base     <= is_accum(kind) ? res : '0;
            pacc     <= '0;
            pend     <= {2'b00, op1_wide, 1'b1};
        end else begin
            if (|pend) pacc <= pacc + pshift;
            pend <= (pend & ~done_bit) | add_bits;
        end
    end

    AST_MUL_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !is_accum(run_kind) |-> !carry);  // R4

endmodule

// File: rtl/mwmac_ready.sv
module mwmac_ready
    import mwmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               start_wide,
    input  logic               hi_load,
    input  logic               op1_wide,
    input  logic               await_hi,
    output logic [N_TRACK-1:0] rdy
);

    logic [N_TRACK-1:0][CNT_W-1:0] cnt;
    logic [N_TRACK-1:0][CNT_W-1:0] dec;
    sched_t                        lo_sched;
    sched_t                        hi_sched;

    assign lo_sched = sched_lookup(op1_wide, start_wide, 1'b0);
    assign hi_sched = sched_lookup(op1_wide, 1'b1, 1'b1);

    genvar gi;
    generate
        for (gi = 0; gi < N_TRACK; gi++) begin : g_trk
            assign dec[gi] = (cnt[gi] == '0) ? '0 : cnt[gi] - 1'b1;
            assign rdy[gi] = (cnt[gi] == '0) && !await_hi;

            always_ff @(posedge clk) begin
                if (rst)          cnt[gi] <= '0;
                else if (start)   cnt[gi] <= lo_sched[gi];
                else if (hi_load) cnt[gi] <= cnt_max(dec[gi], hi_sched[gi]);
                else              cnt[gi] <= dec[gi];
            end
        end
    endgenerate

    AST_RESET_ALL_READY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&rdy));  // R10
    AST_START_HIDES_WORDS: assert property (@(posedge clk) disable iff (rst)
        start |=> (rdy == '0));  // R6

endmodule

// File: rtl/mw_mac_unit.sv
module mw_mac_unit
    import mwmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_byte,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_wait
);

    logic [31:0]        op1;
    logic [31:0]        op2;
    op_kind_e           kind;
    logic               op1_wide;
    logic               await_hi;
    logic               start;
    logic               start_wide;
    logic               hi_load;
    logic [RES_W-1:0]   res;
    logic               carry;
    logic               run_signed;
    logic [3:0]         pend;
    logic [N_TRACK-1:0] rdy;
    logic               word_ok;
    logic [DATA_W-1:0]  ext_word;

    mwmac_regif u_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
        .addr(addr), .wdata(wdata), .op1(op1), .op2(op2), .kind(kind),
        .op1_wide(op1_wide), .await_hi(await_hi), .start(start),
        .start_wide(start_wide), .hi_load(hi_load)
    );

    mwmac_engine u_engine (
        .clk(clk), .rst(rst), .start(start), .start_wide(start_wide),
        .hi_load(hi_load), .kind(kind), .op1(op1), .op2(op2),
        .op1_wide(op1_wide), .res(res), .carry(carry),
        .run_signed(run_signed), .pend(pend)
    );

    mwmac_ready u_ready (
        .clk(clk), .rst(rst), .start(start), .start_wide(start_wide),
        .hi_load(hi_load), .op1_wide(op1_wide), .await_hi(await_hi),
        .rdy(rdy)
    );

    assign ext_word = run_signed ? {DATA_W{res[31]}} : {{(DATA_W-1){1'b0}}, carry};

    always_comb begin
        rd_data = '0;
        word_ok = 1'b1;
        case (addr)
            A_RW0, A_CLO: begin rd_data = res[15:0];  word_ok = rdy[0]; end
            A_RW1, A_CHI: begin rd_data = res[31:16]; word_ok = rdy[1]; end
            A_RW2:        begin rd_data = res[47:32]; word_ok = rdy[2]; end
            A_RW3:        begin rd_data = res[63:48]; word_ok = rdy[3]; end
            A_CEXT:       begin rd_data = ext_word;   word_ok = rdy[1] & rdy[4]; end
            A_CARRY:      begin rd_data = {{(DATA_W-1){1'b0}}, carry}; word_ok = rdy[4]; end
            default:      begin rd_data = '0;         word_ok = 1'b1; end
        endcase
    end

    assign rd_wait = rd_en && !word_ok;

    AST_LOW_WORD_SETTLED: assert property (@(posedge clk) disable iff (rst)
        rdy[0] |-> !pend[0]);  // R6
    AST_TOP_WORD_SETTLED: assert property (@(posedge clk) disable iff (rst)
        rdy[3] |-> (pend == 4'b0000));  // R8

endmodule

// File: tb/mw_mac_unit_bench.sv
`timescale 1ns/1ps
module mw_mac_unit_bench;

    localparam int CLK_PERIOD = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_byte = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rd_wait;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [63:0] mdl_res = '0;
    logic        mdl_cy  = 1'b0;

    mw_mac_unit u_mw_mac_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .addr(addr),
        .wdata(wdata), .rd_en(rd_en), .rd_data(rd_data), .rd_wait(rd_wait)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input bit b);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; wr_byte = b;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d, output logic w);
        rd_en = 1'b1; addr = a;
        #1 d = rd_data; w = rd_wait;
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] ext(input logic [31:0] v, input int w, input bit sg);
        case (w)
            0:       return {{24{sg & v[7]}}, v[7:0]};
            1:       return {{16{sg & v[15]}}, v[15:0]};
            2:       return {{8{sg & v[23]}}, v[23:0]};
            default: return v;
        endcase
    endfunction

    function automatic int deadline(input int i, input bit w1w, input bit w2w,
                                    input bit hi);
        int t [5];
        if (!w2w)          t = w1w ? '{3, 5, 6, 7, 7} : '{3, 3, 4, 4, 3};
        else if (!hi)      t = w1w ? '{3, 8, 10, 11, 11} : '{3, 5, 6, 7, 7};
        else               t = w1w ? '{3, 5, 6, 6, 6} : '{3, 4, 4, 4, 4};
        return t[i];
    endfunction

    task automatic run_op(input int kind, input int w1, input int w2,
                          input logic [31:0] a, input logic [31:0] b,
                          input int g, input string tag);
        bit          sg = kind[0];
        logic [31:0] ea = ext(a, w1, sg);
        logic [31:0] eb = ext(b, w2, sg);
        logic [63:0] prod;
        logic [64:0] sum;
        logic [15:0] d;
        logic        w;
        int          first [5];
        int          exp_t;
        string       treq;

        prod = {{32{sg & ea[31]}}, ea} * {{32{sg & eb[31]}}, eb};
        if (kind >= 2) begin
            sum = {1'b0, mdl_res} + {1'b0, prod};
            mdl_res = sum[63:0]; mdl_cy = sum[64];
        end else begin
            mdl_res = prod; mdl_cy = 1'b0;
        end

        if (w1 < 2) wr(5'(kind), (w1 == 0) ? {8'h00, a[7:0]} : a[15:0], w1 == 0);
        else begin
            wr(5'(8 + kind), a[15:0], 1'b0);
            wr(5'd12, (w1 == 2) ? {8'h00, a[23:16]} : a[31:16], w1 == 2);
        end

        if (w2 < 2) begin
            wr(5'd4, (w2 == 0) ? {8'h00, b[7:0]} : b[15:0], w2 == 0);
            treq = (w1 < 2) ? "R6" : "R7";
        end else begin
            wr(5'd13, b[15:0], 1'b0);
            repeat (g) @(posedge clk);
            if (g >= 4) begin
                #1 rd(5'd16, d, w);
                chk(w == 1'b1, "R8 blocked before high half", 64'(w), 64'd1);
            end
            wr(5'd14, (w2 == 2) ? {8'h00, b[23:16]} : b[31:16], w2 == 2);
            treq = "R8";
        end

        addr = 5'd16; rd_en = 1'b0;
        #1 chk(rd_wait == 1'b0, "R9 idle read strobe", 64'(rd_wait), 64'd0);

        for (int i = 0; i < 5; i++) first[i] = -1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            for (int i = 0; i < 5; i++) begin
                rd(5'(16 + i), d, w);
                if (!w && first[i] < 0) first[i] = k;
            end
        end
        for (int i = 0; i < 5; i++) begin
            if (w2 < 2) exp_t = deadline(i, w1 >= 2, 1'b0, 1'b0);
            else begin
                exp_t = deadline(i, w1 >= 2, 1'b1, 1'b0) - (1 + g);
                if (deadline(i, w1 >= 2, 1'b1, 1'b1) > exp_t)
                    exp_t = deadline(i, w1 >= 2, 1'b1, 1'b1);
            end
            chk(first[i] == exp_t, treq, 64'(first[i]), 64'(exp_t));
        end

        for (int i = 0; i < 4; i++) begin
            rd(5'(16 + i), d, w);
            chk(d == mdl_res[16*i +: 16], tag, 64'(d), 64'(mdl_res[16*i +: 16]));
        end
        rd(5'd20, d, w);
        chk(d == {15'd0, mdl_cy}, "R4", 64'(d), 64'(mdl_cy));
        if (w1 < 2 && w2 < 2) begin
            rd(5'd5, d, w);
            chk(d == mdl_res[15:0], "R5 low", 64'(d), 64'(mdl_res[15:0]));
            rd(5'd6, d, w);
            chk(d == mdl_res[31:16], "R5 high", 64'(d), 64'(mdl_res[31:16]));
            rd(5'd7, d, w);
            exp_t = sg ? (mdl_res[31] ? 32'hFFFF : 0) : int'(mdl_cy);
            chk(d == 16'(exp_t), "R5 ext", 64'(d), 64'(exp_t));
        end
    endtask

    initial begin
        logic [15:0] d;
        logic        w;
        int          gaps [4] = '{0, 1, 2, 5};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            rd(5'(16 + i), d, w);
            chk(d == 16'h0 && w == 1'b0, "R10", {d, 15'd0, w}, 64'd0);
        end

        run_op(1, 0, 0, 32'h0000_00FF, 32'h0000_0001, 0, "R2");
        run_op(0, 0, 0, 32'h0000_00FF, 32'h0000_00FF, 0, "R2");
        run_op(0, 3, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
        run_op(2, 3, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R4");
        run_op(1, 1, 1, 32'h0000_1234, 32'h0000_0010, 0, "R4");
        run_op(1, 3, 3, 32'h8000_0000, 32'h8000_0000, 5, "R3");
        run_op(1, 2, 2, 32'h0080_0000, 32'h007F_FFFF, 5, "R2");
        run_op(3, 1, 1, 32'h0000_8000, 32'h0000_0003, 0, "R5");
        run_op(2, 1, 0, 32'h0000_FFFF, 32'h0000_0080, 0, "R5");
        run_op(1, 0, 3, 32'h0000_0081, 32'h1234_5678, 5, "R8");

        for (int n = 0; n < 60; n++) begin
            run_op($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                   $urandom, $urandom, gaps[$urandom_range(0, 3)], "R1");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule